// File: doc/BRIEF.md
# Four-State Private Cache Line Coherence Controller

This block keeps the coherence state of a small set of lines in one processor's private cache. The processor side issues load, store, flush and evict requests for a line index. A shared interconnect delivers coherence messages from peer CPUs and from memory. The block sends requests, data responses and invalidate acknowledgements back onto that interconnect. Each line is Modified, Exclusive, Shared or Invalid. The data array itself is kept elsewhere; this block only decides state and traffic.

A local request that needs peer cooperation starts a transaction. The controller broadcasts a read, an invalidate or an atomic read-with-invalidate, then counts the replies that come back for that line. The transaction completes only when the read response (if one is needed) and one acknowledgement from every other CPU have arrived. While the transaction is open, and during any cycle in which an incoming message is presented, the request port is back-pressured. Snoops of other lines are still served during this time.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, `req_ready` is 1, and `tx_valid`, `ack_valid` and `cmp_valid` are 0.
- R2: Line states are reported on `cmp_state` as Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. Message opcodes on `rx_op`/`tx_op` are Read=1, ReadResponse=2, Invalidate=3, InvalidateAck=4, ReadInvalidate=5, Writeback=6. Local ops on `req_op` are load=0, store=1, flush=2, evict=3.
- R3: A load to an Invalid line broadcasts Read. It completes as Shared once a ReadResponse for that line arrives.
- R4: A store to an Invalid line broadcasts ReadInvalidate. It completes as Modified only after the ReadResponse and NUM_CPUS-1 InvalidateAcks for that line have arrived, in any order. Replies that name another line are not counted.
- R5: A store to a Shared line broadcasts Invalidate and completes as Modified after NUM_CPUS-1 InvalidateAcks.
- R6: A store to an Exclusive or Modified line completes as Modified with no message. A load to a Shared, Exclusive or Modified line completes with its state unchanged and no message.
- R7: A flush of a Modified line broadcasts Writeback and completes as Exclusive. A flush of any other line sends nothing and leaves the state as it is.
- R8: An evict of a Modified line broadcasts Writeback. An evict of any line completes as Invalid.
- R9: An incoming Read makes a Modified line send a ReadResponse to the sender (`tx_bcast`=0) and become Shared. It makes an Exclusive line become Shared with no reply. Shared and Invalid lines are unaffected.
- R10: An incoming ReadInvalidate leaves the line Invalid and always returns an InvalidateAck to the sender. A Modified line also sends a ReadResponse in the same cycle.
- R11: An incoming Invalidate leaves the line Invalid and returns an InvalidateAck to the sender.
- R12: `req_ready` is 0 while a transaction is open or while `rx_valid` is 1. No request is accepted then.
- R13: `cmp_valid` is a one-cycle pulse. It appears the cycle after acceptance for requests that need no reply, and otherwise the cycle after the last awaited reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | Local op: load, store, flush, evict |
| req_line | input | clog2(NUM_LINES) | Line index of the local request |
| req_ready | output | 1 | Local request may be accepted |
| cmp_valid | output | 1 | Local request completed |
| cmp_line | output | clog2(NUM_LINES) | Line of the completed request |
| cmp_state | output | 2 | Line state after completion |
| rx_valid | input | 1 | Incoming message present |
| rx_op | input | 3 | Incoming message opcode |
| rx_line | input | clog2(NUM_LINES) | Line named by incoming message |
| rx_src | input | clog2(NUM_CPUS) | Sender of incoming message |
| tx_valid | output | 1 | Outgoing request or data response |
| tx_op | output | 3 | Outgoing opcode |
| tx_line | output | clog2(NUM_LINES) | Line named by outgoing message |
| tx_dst | output | clog2(NUM_CPUS) | Destination when not broadcast |
| tx_bcast | output | 1 | Outgoing message goes to all agents |
| ack_valid | output | 1 | Outgoing InvalidateAck present |
| ack_line | output | clog2(NUM_LINES) | Line being acknowledged |
| ack_dst | output | clog2(NUM_CPUS) | CPU receiving the acknowledgement |

## Verification
The hardest cases to reach are those where completion depends on reply order. One is a ReadInvalidate whose acknowledgements all arrive before the data response. Another is an upgrade that receives acknowledgements naming a different line while its own are still outstanding. The bench plays the whole interconnect. It holds back or reorders the replies it feeds on `rx_*` and samples `cmp_valid` after each one, so it can confirm that completion waits for the final awaited message and for no other. It also first drives lines into Modified and Exclusive through full local transactions, so that the snoop cases that depend on those states can be reached at all.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_e;

    typedef enum logic [2:0] {
        MSG_NONE    = 3'd0,
        MSG_RD      = 3'd1,
        MSG_RD_RESP = 3'd2,
        MSG_INV     = 3'd3,
        MSG_INV_ACK = 3'd4,
        MSG_RD_INV  = 3'd5,
        MSG_WB      = 3'd6
    } msg_op_e;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_STORE = 2'd1,
        REQ_FLUSH = 2'd2,
        REQ_EVICT = 2'd3
    } req_op_e;

    // Outcome of a local request applied to the current line state
    typedef struct packed {
        logic        immediate;
        line_state_e final_state;
        msg_op_e     tx_op;
        logic        need_resp;
        logic        need_acks;
    } local_plan_t;

    // Outcome of a peer message applied to the current line state
    typedef struct packed {
        line_state_e next_state;
        logic        give_data;
        logic        give_ack;
    } snoop_plan_t;

    function automatic logic is_snoop_op(msg_op_e op);
        return (op == MSG_RD) || (op == MSG_RD_INV) || (op == MSG_INV);
    endfunction

endpackage

// File: rtl/mesi_local_decode.sv
module mesi_local_decode
    import mesi_pkg::*;
(
    input  req_op_e     op,
    input  line_state_e cur,
    output local_plan_t plan
);
    always_comb begin
        plan.immediate   = 1'b1;
        plan.final_state = cur;
        plan.tx_op       = MSG_NONE;
        plan.need_resp   = 1'b0;
        plan.need_acks   = 1'b0;
        unique case (op)
            REQ_LOAD: begin
                if (cur == ST_I) begin
                    plan.immediate   = 1'b0;
                    plan.tx_op       = MSG_RD;
                    plan.need_resp   = 1'b1;
                    plan.final_state = ST_S;
                end
            end
            REQ_STORE: begin
                plan.final_state = ST_M;
                if (cur == ST_I) begin
                    plan.immediate = 1'b0;
                    plan.tx_op     = MSG_RD_INV;
                    plan.need_resp = 1'b1;
                    plan.need_acks = 1'b1;
                end else if (cur == ST_S) begin
                    plan.immediate = 1'b0;
                    plan.tx_op     = MSG_INV;
                    plan.need_acks = 1'b1;
                end
            end
            REQ_FLUSH: begin
                if (cur == ST_M) begin
                    plan.tx_op       = MSG_WB;
                    plan.final_state = ST_E;
                end
            end
            REQ_EVICT: begin
                plan.final_state = ST_I;
                if (cur == ST_M) begin
                    plan.tx_op = MSG_WB;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_snoop_decode.sv
module mesi_snoop_decode
    import mesi_pkg::*;
(
    input  msg_op_e     op,
    input  line_state_e cur,
    output snoop_plan_t plan
);
    always_comb begin
        plan.next_state = cur;
        plan.give_data  = 1'b0;
        plan.give_ack   = 1'b0;
        unique case (op)
            MSG_RD: begin
                if (cur == ST_M) begin
                    plan.give_data  = 1'b1;
                    plan.next_state = ST_S;
                end else if (cur == ST_E) begin
                    plan.next_state = ST_S;
                end
            end
            MSG_RD_INV: begin
                plan.give_data  = (cur == ST_M);
                plan.give_ack   = 1'b1;
                plan.next_state = ST_I;
            end
            MSG_INV: begin
                plan.give_ack   = 1'b1;
                plan.next_state = ST_I;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_txn_tracker.sv
module mesi_txn_tracker
    import mesi_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int LINE_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  line_state_e       start_final,
    input  logic              start_need_resp,
    input  logic              start_need_acks,
    input  logic              rx_valid,
    input  msg_op_e           rx_op,
    input  logic [LINE_W-1:0] rx_line,
    output logic              busy,
    output logic              finish,
    output logic [LINE_W-1:0] pend_line,
    output line_state_e       pend_final
);
    localparam int CNT_W = $clog2(NUM_CPUS) + 1;
    localparam logic [CNT_W-1:0] PEERS = CNT_W'(NUM_CPUS - 1);

    logic              busy_q;
    logic [LINE_W-1:0] line_q;
    line_state_e       final_q;
    logic              need_resp_q;
    logic              need_acks_q;
    logic              got_resp_q;
    logic [CNT_W-1:0]  ack_cnt_q;

    logic              hit;
    logic              resp_now;
    logic [CNT_W-1:0]  cnt_now;

    assign hit      = busy_q && rx_valid && (rx_line == line_q);
    assign resp_now = got_resp_q || (hit && rx_op == MSG_RD_RESP);
    assign cnt_now  = ack_cnt_q + CNT_W'(hit && rx_op == MSG_INV_ACK);
    assign finish   = busy_q && (!need_resp_q || resp_now)
                    && (!need_acks_q || cnt_now >= PEERS);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            line_q      <= '0;
            final_q     <= ST_I;
            need_resp_q <= 1'b0;
            need_acks_q <= 1'b0;
            got_resp_q  <= 1'b0;
            ack_cnt_q   <= '0;
        end else if (start) begin
            busy_q      <= 1'b1;
            line_q      <= start_line;
            final_q     <= start_final;
            need_resp_q <= start_need_resp;
            need_acks_q <= start_need_acks;
            got_resp_q  <= 1'b0;
            ack_cnt_q   <= '0;
        end else if (finish) begin
            busy_q      <= 1'b0;
        end else begin
            got_resp_q  <= resp_now;
            ack_cnt_q   <= cnt_now;
        end
    end

    assign busy       = busy_q;
    assign pend_line  = line_q;
    assign pend_final = final_q;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_LINES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NUM_LINES)-1:0] req_line,
    output logic                         req_ready,
    output logic                         cmp_valid,
    output logic [$clog2(NUM_LINES)-1:0] cmp_line,
    output logic [1:0]                   cmp_state,
    input  logic                         rx_valid,
    input  logic [2:0]                   rx_op,
    input  logic [$clog2(NUM_LINES)-1:0] rx_line,
    input  logic [$clog2(NUM_CPUS)-1:0]  rx_src,
    output logic                         tx_valid,
    output logic [2:0]                   tx_op,
    output logic [$clog2(NUM_LINES)-1:0] tx_line,
    output logic [$clog2(NUM_CPUS)-1:0]  tx_dst,
    output logic                         tx_bcast,
    output logic                         ack_valid,
    output logic [$clog2(NUM_LINES)-1:0] ack_line,
    output logic [$clog2(NUM_CPUS)-1:0]  ack_dst
);
    localparam int LINE_W = $clog2(NUM_LINES);
    localparam int SRC_W  = $clog2(NUM_CPUS);

    line_state_e       state_vec [NUM_LINES];
    line_state_e       req_cur;
    line_state_e       rx_cur;
    msg_op_e           rx_msg;
    local_plan_t       lplan;
    snoop_plan_t       splan;
    logic              busy;
    logic              finish;
    logic [LINE_W-1:0] pend_line;
    line_state_e       pend_final;
    logic              accept;
    logic              snoop_act;

    assign rx_msg    = msg_op_e'(rx_op);
    assign req_cur   = state_vec[req_line];
    assign rx_cur    = state_vec[rx_line];
    assign req_ready = !busy && !rx_valid;
    assign accept    = req_valid && req_ready;
    assign snoop_act = rx_valid && is_snoop_op(rx_msg);

    mesi_local_decode u_local (
        .op   (req_op_e'(req_op)),
        .cur  (req_cur),
        .plan (lplan)
    );

    mesi_snoop_decode u_snoop (
        .op   (rx_msg),
        .cur  (rx_cur),
        .plan (splan)
    );

    mesi_txn_tracker #(
        .NUM_CPUS (NUM_CPUS),
        .LINE_W   (LINE_W)
    ) u_track (
        .clk             (clk),
        .rst             (rst),
        .start           (accept && !lplan.immediate),
        .start_line      (req_line),
        .start_final     (lplan.final_state),
        .start_need_resp (lplan.need_resp),
        .start_need_acks (lplan.need_acks),
        .rx_valid        (rx_valid),
        .rx_op           (rx_msg),
        .rx_line         (rx_line),
        .busy            (busy),
        .finish          (finish),
        .pend_line       (pend_line),
        .pend_final      (pend_final)
    );

    // One state register per line; snoop, immediate local and completion
    // never coincide on the same cycle, so the order below is a formality.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_e st_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= ST_I;
            end else if (snoop_act && rx_line == LINE_W'(g)) begin
                st_q <= splan.next_state;
            end else if (accept && lplan.immediate && req_line == LINE_W'(g)) begin
                st_q <= lplan.final_state;
            end else if (finish && pend_line == LINE_W'(g)) begin
                st_q <= pend_final;
            end
        end
        assign state_vec[g] = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid  <= 1'b0;
            tx_op     <= MSG_NONE;
            tx_line   <= '0;
            tx_dst    <= '0;
            tx_bcast  <= 1'b0;
            ack_valid <= 1'b0;
            ack_line  <= '0;
            ack_dst   <= '0;
            cmp_valid <= 1'b0;
            cmp_line  <= '0;
            cmp_state <= ST_I;
        end else begin
            tx_valid  <= 1'b0;
            ack_valid <= 1'b0;
            cmp_valid <= 1'b0;
            if (accept) begin
                if (lplan.tx_op != MSG_NONE) begin
                    tx_valid <= 1'b1;
                    tx_op    <= lplan.tx_op;
                    tx_line  <= req_line;
                    tx_dst   <= '0;
                    tx_bcast <= 1'b1;
                end
                if (lplan.immediate) begin
                    cmp_valid <= 1'b1;
                    cmp_line  <= req_line;
                    cmp_state <= lplan.final_state;
                end
            end
            if (finish) begin
                cmp_valid <= 1'b1;
                cmp_line  <= pend_line;
                cmp_state <= pend_final;
            end
            if (snoop_act) begin
                if (splan.give_data) begin
                    tx_valid <= 1'b1;
                    tx_op    <= MSG_RD_RESP;
                    tx_line  <= rx_line;
                    tx_dst   <= SRC_W'(rx_src);
                    tx_bcast <= 1'b0;
                end
                if (splan.give_ack) begin
                    ack_valid <= 1'b1;
                    ack_line  <= rx_line;
                    ack_dst   <= rx_src;
                end
            end
        end
    end
endmodule

// File: rtl/mesi_line_ctrl_checker.sv
module mesi_line_ctrl_checker #(
    parameter int NUM_CPUS = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic                        busy,
    input logic                        rx_valid,
    input logic [$clog2(NUM_CPUS)-1:0] rx_src,
    input logic                        tx_valid,
    input logic [2:0]                  tx_op,
    input logic                        tx_bcast,
    input logic                        ack_valid,
    input logic [$clog2(NUM_CPUS)-1:0] ack_dst,
    input logic                        cmp_valid
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !ack_valid && !cmp_valid));

    assert_opcode_legal_R2: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_op == 3'd1 || tx_op == 3'd2 || tx_op == 3'd3
                      || tx_op == 3'd5 || tx_op == 3'd6));

    assert_request_from_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_bcast) |-> $past(req_valid && req_ready));

    assert_open_txn_no_cmp_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !cmp_valid);

    assert_data_from_snoop_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_bcast) |-> ($past(rx_valid) && tx_op == 3'd2));

    assert_ack_to_sender_R11: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> ($past(rx_valid) && ack_dst == $past(rx_src)));

    assert_backpressure_R12: assert property (@(posedge clk) disable iff (rst)
        (busy || rx_valid) |-> !req_ready);

    assert_cmp_cause_R13: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> ($past(req_valid && req_ready) || $past(rx_valid)));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_checker #(
    .NUM_CPUS (NUM_CPUS)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .rx_src    (rx_src),
    .tx_valid  (tx_valid),
    .tx_op     (tx_op),
    .tx_bcast  (tx_bcast),
    .ack_valid (ack_valid),
    .ack_dst   (ack_dst),
    .cmp_valid (cmp_valid)
);

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/100ps
module mesi_line_ctrl_bench;
    localparam int NUM_CPUS  = 4;
    localparam int NUM_LINES = 4;

    // opcode / state constants as defined in the requirements (R2)
    localparam int OP_LD = 0, OP_ST = 1, OP_FL = 2, OP_EV = 3;
    localparam int M_NONE = 0, M_RD = 1, M_RESP = 2, M_INV = 3, M_ACK = 4, M_RDI = 5, M_WB = 6;
    localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [1:0] req_line = '0;
    logic       req_ready;
    logic       cmp_valid;
    logic [1:0] cmp_line;
    logic [1:0] cmp_state;
    logic       rx_valid = 1'b0;
    logic [2:0] rx_op = '0;
    logic [1:0] rx_line = '0;
    logic [1:0] rx_src = '0;
    logic       tx_valid;
    logic [2:0] tx_op;
    logic [1:0] tx_line;
    logic [1:0] tx_dst;
    logic       tx_bcast;
    logic       ack_valid;
    logic [1:0] ack_line;
    logic [1:0] ack_dst;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_mesi_line_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_line(req_line), .req_ready(req_ready),
        .cmp_valid(cmp_valid), .cmp_line(cmp_line), .cmp_state(cmp_state),
        .rx_valid(rx_valid), .rx_op(rx_op), .rx_line(rx_line), .rx_src(rx_src),
        .tx_valid(tx_valid), .tx_op(tx_op), .tx_line(tx_line), .tx_dst(tx_dst), .tx_bcast(tx_bcast),
        .ack_valid(ack_valid), .ack_line(ack_line), .ack_dst(ack_dst)
    );

    // {op, line, expected tx opcode (0 = none), expected final state}
    localparam logic [8:0] VEC [16] = '{
        {2'd0, 2'd0, 3'd1, 2'd1},
        {2'd0, 2'd0, 3'd0, 2'd1},
        {2'd1, 2'd0, 3'd3, 2'd3},
        {2'd0, 2'd0, 3'd0, 2'd3},
        {2'd2, 2'd0, 3'd6, 2'd2},
        {2'd1, 2'd0, 3'd0, 2'd3},
        {2'd3, 2'd0, 3'd6, 2'd0},
        {2'd1, 2'd1, 3'd5, 2'd3},
        {2'd2, 2'd2, 3'd0, 2'd0},
        {2'd0, 2'd2, 3'd1, 2'd1},
        {2'd3, 2'd2, 3'd0, 2'd0},
        {2'd1, 2'd3, 3'd5, 2'd3},
        {2'd2, 2'd3, 3'd6, 2'd2},
        {2'd0, 2'd3, 3'd0, 2'd2},
        {2'd3, 2'd3, 3'd0, 2'd0},
        {2'd0, 2'd1, 3'd0, 2'd3}
    };

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string vtag(input int op, input int etx);
        if (op == OP_LD && etx == M_RD) return "R3";
        if (op == OP_ST && etx == M_RDI) return "R4";
        if (op == OP_ST && etx == M_INV) return "R5";
        if (op == OP_FL) return "R7";
        if (op == OP_EV) return "R8";
        return "R6";
    endfunction

    // called at a negedge; returns at the negedge after acceptance
    task automatic apply_req(input int op, input int line);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_line  = 2'(line);
        #1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // called at a negedge; message is held for one clock edge
    task automatic send_rx(input int op, input int line, input int src);
        rx_valid = 1'b1;
        rx_op    = 3'(op);
        rx_line  = 2'(line);
        rx_src   = 2'(src);
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic run_op(input int op, input int line, input int etx, input int est, input string tag);
        int seen;
        apply_req(op, line);
        seen = tx_valid ? int'(tx_op) : 0;
        chk(seen == etx, tag, "request opcode", seen, etx);
        if (seen == M_RD) begin
            send_rx(M_RESP, line, 1);
        end else if (seen == M_RDI) begin
            send_rx(M_RESP, line, 1);
            for (int p = 1; p < NUM_CPUS; p++) send_rx(M_ACK, line, p);
        end else if (seen == M_INV) begin
            for (int p = 1; p < NUM_CPUS; p++) send_rx(M_ACK, line, p);
        end
        chk(cmp_valid && int'(cmp_line) == line && int'(cmp_state) == est,
            $sformatf("%s R13 R2", tag), "completion state",
            cmp_valid ? int'(cmp_state) : -1, est);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(!tx_valid && !ack_valid && !cmp_valid, "R1", "outputs idle",
            int'({tx_valid, ack_valid, cmp_valid}), 0);

        for (int i = 0; i < 16; i++) begin
            int op, line, etx, est;
            op   = int'(VEC[i][8:7]);
            line = int'(VEC[i][6:5]);
            etx  = int'(VEC[i][4:2]);
            est  = int'(VEC[i][1:0]);
            run_op(op, line, etx, est, vtag(op, etx));
        end
        // now: line0 I, line1 M, line2 I, line3 I

        // R9: Read to a Modified line; also R12 back-pressure while rx_valid
        rx_valid = 1'b1; rx_op = 3'(M_RD); rx_line = 2'd1; rx_src = 2'd2;
        req_valid = 1'b1; req_op = 2'(OP_LD); req_line = 2'd0;
        #1;
        chk(req_ready == 1'b0, "R12", "ready during rx", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0; req_valid = 1'b0;
        chk(tx_valid && int'(tx_op) == M_RESP && !tx_bcast && tx_dst == 2'd2 && tx_line == 2'd1,
            "R9", "data reply", int'(tx_op), M_RESP);
        chk(!ack_valid, "R9", "no ack on read", int'(ack_valid), 0);
        chk(!cmp_valid, "R12", "held request not accepted", int'(cmp_valid), 0);
        run_op(OP_LD, 1, M_NONE, S_S, "R9");

        // R9: Read to an Exclusive line goes Shared silently
        run_op(OP_ST, 3, M_RDI, S_M, "R4");
        run_op(OP_FL, 3, M_WB, S_E, "R7");
        send_rx(M_RD, 3, 3);
        chk(!tx_valid && !ack_valid, "R9", "exclusive read silent",
            int'({tx_valid, ack_valid}), 0);
        run_op(OP_LD, 3, M_NONE, S_S, "R9");

        // R10: ReadInvalidate to a Modified line
        run_op(OP_ST, 0, M_RDI, S_M, "R4");
        send_rx(M_RDI, 0, 2);
        chk(tx_valid && int'(tx_op) == M_RESP && tx_dst == 2'd2, "R10", "data reply",
            int'(tx_op), M_RESP);
        chk(ack_valid && ack_dst == 2'd2 && ack_line == 2'd0, "R10", "ack to sender",
            int'(ack_valid), 1);
        run_op(OP_LD, 0, M_RD, S_S, "R10");

        // R11: Invalidate on a Shared line
        send_rx(M_INV, 0, 1);
        chk(ack_valid && ack_dst == 2'd1 && !tx_valid, "R11", "ack only",
            int'(ack_valid), 1);
        run_op(OP_LD, 0, M_RD, S_S, "R11");

        // R10: ReadInvalidate to an Invalid line still acknowledged
        send_rx(M_RDI, 2, 3);
        chk(ack_valid && ack_dst == 2'd3 && !tx_valid, "R10", "ack from invalid",
            int'({ack_valid, tx_valid}), 2);

        // R4 ordering: acks before response; R12 ready low while open; R13 pulse
        apply_req(OP_ST, 2);
        chk(tx_valid && int'(tx_op) == M_RDI, "R4", "read-invalidate sent", int'(tx_op), M_RDI);
        req_valid = 1'b1; req_op = 2'(OP_LD); req_line = 2'd1;
        #1;
        chk(req_ready == 1'b0, "R12", "ready while open", int'(req_ready), 0);
        req_valid = 1'b0;
        for (int p = 1; p < NUM_CPUS; p++) send_rx(M_ACK, 2, p);
        chk(!cmp_valid, "R4", "no completion before response", int'(cmp_valid), 0);
        send_rx(M_RESP, 2, 1);
        chk(cmp_valid && int'(cmp_state) == S_M && cmp_line == 2'd2, "R4", "complete after response",
            cmp_valid ? int'(cmp_state) : -1, S_M);
        @(negedge clk);
        chk(!cmp_valid, "R13", "single-cycle pulse", int'(cmp_valid), 0);

        // R5: completion only on the last peer ack
        apply_req(OP_ST, 0);
        chk(tx_valid && int'(tx_op) == M_INV, "R5", "invalidate sent", int'(tx_op), M_INV);
        send_rx(M_ACK, 0, 1);
        send_rx(M_ACK, 0, 2);
        chk(!cmp_valid, "R5", "two of three acks", int'(cmp_valid), 0);
        send_rx(M_ACK, 0, 3);
        chk(cmp_valid && int'(cmp_state) == S_M, "R5", "third ack completes",
            cmp_valid ? int'(cmp_state) : -1, S_M);

        // R4/R5: acks naming another line are not counted
        apply_req(OP_ST, 3);
        chk(tx_valid && int'(tx_op) == M_INV, "R5", "upgrade sent", int'(tx_op), M_INV);
        for (int p = 1; p < NUM_CPUS; p++) send_rx(M_ACK, 1, p);
        chk(!cmp_valid, "R4", "foreign acks ignored", int'(cmp_valid), 0);
        for (int p = 1; p < NUM_CPUS; p++) send_rx(M_ACK, 3, p);
        chk(cmp_valid && int'(cmp_state) == S_M && cmp_line == 2'd3, "R5", "own acks complete",
            cmp_valid ? int'(cmp_state) : -1, S_M);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule